// File: doc/BRIEF.md
# Read/Write Turnaround Arbiter

This block chooses whether a memory controller's command stream serves reads or writes at any moment. It keeps an occupancy count for a read queue and a small write store of burst addresses. The write store is kept in arrival order. The direction moves to writes when writes pile up. It returns to reads once enough writes have drained. A minimum number of writes must issue in each write phase, so that the costly bus turnaround is not paid for a single write.

On the request side, a read is answered straight from the write store when it hits a pending write's burst address. A write to a burst address that is already pending folds into that entry. A request that finds its queue full is refused, and a one-cycle retry pulse is raised once a slot frees. Each time the direction flips, the block presents the extra delay that the first command of the new phase must carry. The value differs for a change to reads and a change to writes. Bank timing and DRAM command generation are left to other logic.

Top module: `rw_turn_arbiter`

## Requirements
- R1: The high mark is WQ_DEPTH*HI_PCT/100 (6 by default) and the low mark is WQ_DEPTH*LO_PCT/100 (2 by default). In read mode, a write level at or above the high mark puts the bus in write mode at the next clock edge, even when reads are queued.
- R2: In read mode, an empty read queue together with a non-zero write level at or above the low mark turns the bus to writes at the next edge. While a read is queued, a write level below the high mark does not.
- R3: In write mode with writes pending, the bus stays in write mode until at least MIN_WR writes (2 by default) have issued in the current phase.
- R4: In write mode the bus returns to reads at the next edge once the write level is zero, or once the write level is below the low mark and the minimum write count has been met.
- R5: A read whose burst address equals a pending write's address is accepted with rdForward high in the same cycle and does not raise the read level. Any other accepted read raises the read level by one.
- R6: A write whose burst address equals a pending write's address is accepted with wrMerge high and leaves the write level unchanged. Any other accepted write raises the write level by one.
- R7: A request arriving when its queue is full (read level RQ_DEPTH, 4 by default; write level WQ_DEPTH, 8 by default) is refused with its accept output low. The matching retry output then pulses for exactly one cycle, starting in the first cycle in which the level is below full.
- R8: The turnDelay output is CS_DLY (2 by default) after a change to reads and min(RTW_DLY, CS_DLY) (1 by default) after a change to writes. It returns to zero after the first issue of the new phase.
- R9: phaseCnt counts the issues of the current direction. It is zero in the cycle after every direction change.
- R10: An issue pulse for the direction not currently selected, or for an empty queue, changes neither level nor phaseCnt.
- R11: After reset the bus is in read mode, both levels are zero, turnDelay is zero and phaseCnt is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReqValid | input | 1 | Read request present this cycle |
| rdReqAddr | input | AW | Burst address of the read |
| wrReqValid | input | 1 | Write request present this cycle |
| wrReqAddr | input | AW | Burst address of the write |
| rdIssue | input | 1 | Oldest read sent to DRAM this cycle |
| wrIssue | input | 1 | Oldest write sent to DRAM this cycle |
| busIsWrite | output | 1 | Current direction, 1 means writes |
| rdAccept | output | 1 | Read request taken |
| rdForward | output | 1 | Taken read served from the write store |
| rdRetry | output | 1 | Refused read may now be resent |
| wrAccept | output | 1 | Write request taken |
| wrMerge | output | 1 | Taken write folded into a pending entry |
| wrRetry | output | 1 | Refused write may now be resent |
| turnDelay | output | DLY_W | Extra delay for the first command after a turn |
| rdLevel | output | clog2(RQ_DEPTH+1) | Reads queued |
| wrLevel | output | clog2(WQ_DEPTH+1) | Distinct writes pending |
| phaseCnt | output | PH_W | Issues in the current phase |

## Verification
Direction control is tried with three patterns. A small write backlog with an idle read queue separates the low-mark drain and its minimum-write hold from the empty-queue return. Six writes with a read still queued show that the high mark alone forces the turn. A full write store drained one entry at a time shows the return below the low mark once the minimum is met. Request handling is tried with repeated and distinct addresses, which separates forwarding and merging from normal allocation. Full queues on both sides show the refusal and the single retry pulse. Issue pulses in the wrong direction show that they are ignored.

// File: rtl/rwta_pkg.sv
package rwta_pkg;
  typedef struct packed {
    logic rdPush;
    logic rdPop;
    logic wrPush;
    logic wrPop;
  } rwta_strobe_t;
endpackage

// File: rtl/rwta_datapath.sv
module rwta_datapath
  import rwta_pkg::*;
#(
  parameter int WQ_DEPTH = 8,
  parameter int RQ_DEPTH = 4,
  parameter int AW       = 16,
  localparam int WL_W    = $clog2(WQ_DEPTH + 1),
  localparam int RL_W    = $clog2(RQ_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  rwta_strobe_t    strb,
  input  logic [AW-1:0]   wrAddr,
  input  logic [AW-1:0]   rdAddr,
  output logic            wrHitHead,
  output logic            wrHitRest,
  output logic            rdHit,
  output logic [WL_W-1:0] wrLevel,
  output logic [RL_W-1:0] rdLevel
);
  logic [AW-1:0]       entAddr [WQ_DEPTH];
  logic [WQ_DEPTH-1:0] entVld;
  logic [WL_W-1:0]     slot;

  always_comb begin
    wrHitHead = entVld[0] && (entAddr[0] == wrAddr);
    wrHitRest = 1'b0;
    rdHit     = 1'b0;
    for (int i = 0; i < WQ_DEPTH; i++) begin
      if (entVld[i] && entAddr[i] == rdAddr) rdHit = 1'b1;
      if (i > 0 && entVld[i] && entAddr[i] == wrAddr) wrHitRest = 1'b1;
    end
    slot = wrLevel - WL_W'(strb.wrPop);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entVld  <= '0;
      wrLevel <= '0;
      rdLevel <= '0;
      for (int i = 0; i < WQ_DEPTH; i++) entAddr[i] <= '0;
    end else begin
      if (strb.wrPop) begin
        for (int i = 0; i < WQ_DEPTH - 1; i++) begin
          entVld[i]  <= entVld[i+1];
          entAddr[i] <= entAddr[i+1];
        end
        entVld[WQ_DEPTH-1] <= 1'b0;
      end
      if (strb.wrPush) begin
        entVld[slot]  <= 1'b1;
        entAddr[slot] <= wrAddr;
      end
      wrLevel <= wrLevel + WL_W'(strb.wrPush) - WL_W'(strb.wrPop);
      rdLevel <= rdLevel + RL_W'(strb.rdPush) - RL_W'(strb.rdPop);
    end
  end
endmodule

// File: rtl/rwta_control.sv
module rwta_control
  import rwta_pkg::*;
#(
  parameter int WQ_DEPTH = 8,
  parameter int RQ_DEPTH = 4,
  parameter int HI_PCT   = 75,
  parameter int LO_PCT   = 25,
  parameter int MIN_WR   = 2,
  parameter int CS_DLY   = 2,
  parameter int RTW_DLY  = 1,
  parameter int DLY_W    = 4,
  parameter int PH_W     = 8,
  localparam int WL_W    = $clog2(WQ_DEPTH + 1),
  localparam int RL_W    = $clog2(RQ_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdReqValid,
  input  logic             wrReqValid,
  input  logic             rdIssue,
  input  logic             wrIssue,
  input  logic             wrHitHead,
  input  logic             wrHitRest,
  input  logic             rdHit,
  input  logic [WL_W-1:0]  wrLevel,
  input  logic [RL_W-1:0]  rdLevel,
  output rwta_strobe_t     strb,
  output logic             busIsWrite,
  output logic             rdAccept,
  output logic             rdForward,
  output logic             rdRetry,
  output logic             wrAccept,
  output logic             wrMerge,
  output logic             wrRetry,
  output logic [DLY_W-1:0] turnDelay,
  output logic [PH_W-1:0]  phaseCnt
);
  localparam int HI_MARK = WQ_DEPTH * HI_PCT / 100;
  localparam int LO_MARK = WQ_DEPTH * LO_PCT / 100;
  localparam logic [WL_W-1:0] HI_L = WL_W'(HI_MARK);
  localparam logic [WL_W-1:0] LO_L = WL_W'(LO_MARK);
  localparam logic [WL_W-1:0] WFULL = WL_W'(WQ_DEPTH);
  localparam logic [RL_W-1:0] RFULL = RL_W'(RQ_DEPTH);
  localparam logic [DLY_W-1:0] TO_RD = DLY_W'(CS_DLY);
  localparam logic [DLY_W-1:0] TO_WR = DLY_W'((RTW_DLY < CS_DLY) ? RTW_DLY : CS_DLY);
  localparam logic [PH_W-1:0] MIN_L = PH_W'(MIN_WR);

  generate
    if (LO_PCT >= HI_PCT) begin : g_bad_marks
      $error("low watermark percentage must be below the high one");
    end
  endgenerate

  logic rdPend, wrPend, goWr, goRd, issued;

  always_comb begin
    rdAccept    = rdReqValid && (rdLevel != RFULL);
    rdForward   = rdAccept && rdHit;
    wrAccept    = wrReqValid && (wrLevel != WFULL);
    strb.wrPop  = wrIssue && busIsWrite && (wrLevel != '0);
    strb.rdPop  = rdIssue && !busIsWrite && (rdLevel != '0);
    wrMerge     = wrAccept && (wrHitRest || (wrHitHead && !strb.wrPop));
    strb.wrPush = wrAccept && !wrMerge;
    strb.rdPush = rdAccept && !rdHit;
    rdRetry     = rdPend && (rdLevel != RFULL);
    wrRetry     = wrPend && (wrLevel != WFULL);
    goWr = !busIsWrite && (wrLevel != '0) &&
           ((wrLevel >= HI_L) || ((rdLevel == '0) && (wrLevel >= LO_L)));
    goRd = busIsWrite && ((wrLevel == '0) || ((wrLevel < LO_L) && (phaseCnt >= MIN_L)));
    issued = strb.wrPop || strb.rdPop;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busIsWrite <= 1'b0;
      phaseCnt   <= '0;
      turnDelay  <= '0;
      rdPend     <= 1'b0;
      wrPend     <= 1'b0;
    end else begin
      rdPend <= (rdPend && !rdRetry) || (rdReqValid && !rdAccept);
      wrPend <= (wrPend && !wrRetry) || (wrReqValid && !wrAccept);
      if (goWr || goRd) begin
        busIsWrite <= goWr;
        phaseCnt   <= '0;
        turnDelay  <= goRd ? TO_RD : TO_WR;
      end else if (issued) begin
        if (phaseCnt != '1) phaseCnt <= phaseCnt + 1'b1;
        turnDelay <= '0;
      end
    end
  end
endmodule

// File: rtl/rw_turn_arbiter.sv
module rw_turn_arbiter
  import rwta_pkg::*;
#(
  parameter int WQ_DEPTH = 8,
  parameter int RQ_DEPTH = 4,
  parameter int AW       = 16,
  parameter int HI_PCT   = 75,
  parameter int LO_PCT   = 25,
  parameter int MIN_WR   = 2,
  parameter int CS_DLY   = 2,
  parameter int RTW_DLY  = 1,
  parameter int DLY_W    = 4,
  parameter int PH_W     = 8,
  localparam int WL_W    = $clog2(WQ_DEPTH + 1),
  localparam int RL_W    = $clog2(RQ_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdReqValid,
  input  logic [AW-1:0]    rdReqAddr,
  input  logic             wrReqValid,
  input  logic [AW-1:0]    wrReqAddr,
  input  logic             rdIssue,
  input  logic             wrIssue,
  output logic             busIsWrite,
  output logic             rdAccept,
  output logic             rdForward,
  output logic             rdRetry,
  output logic             wrAccept,
  output logic             wrMerge,
  output logic             wrRetry,
  output logic [DLY_W-1:0] turnDelay,
  output logic [RL_W-1:0]  rdLevel,
  output logic [WL_W-1:0]  wrLevel,
  output logic [PH_W-1:0]  phaseCnt
);
  rwta_strobe_t strb;
  logic wrHitHead, wrHitRest, rdHit;

  rwta_datapath #(.WQ_DEPTH(WQ_DEPTH), .RQ_DEPTH(RQ_DEPTH), .AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrReqAddr), .rdAddr(rdReqAddr),
    .wrHitHead(wrHitHead), .wrHitRest(wrHitRest), .rdHit(rdHit),
    .wrLevel(wrLevel), .rdLevel(rdLevel)
  );

  rwta_control #(
    .WQ_DEPTH(WQ_DEPTH), .RQ_DEPTH(RQ_DEPTH), .HI_PCT(HI_PCT), .LO_PCT(LO_PCT),
    .MIN_WR(MIN_WR), .CS_DLY(CS_DLY), .RTW_DLY(RTW_DLY), .DLY_W(DLY_W), .PH_W(PH_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .rdReqValid(rdReqValid), .wrReqValid(wrReqValid),
    .rdIssue(rdIssue), .wrIssue(wrIssue), .wrHitHead(wrHitHead), .wrHitRest(wrHitRest),
    .rdHit(rdHit), .wrLevel(wrLevel), .rdLevel(rdLevel), .strb(strb),
    .busIsWrite(busIsWrite), .rdAccept(rdAccept), .rdForward(rdForward), .rdRetry(rdRetry),
    .wrAccept(wrAccept), .wrMerge(wrMerge), .wrRetry(wrRetry),
    .turnDelay(turnDelay), .phaseCnt(phaseCnt)
  );
endmodule

// File: rtl/rwta_checker.sv
module rwta_checker #(
  parameter int WQ_DEPTH = 8,
  parameter int RQ_DEPTH = 4,
  parameter int HI_PCT   = 75,
  parameter int LO_PCT   = 25,
  parameter int MIN_WR   = 2,
  parameter int CS_DLY   = 2,
  parameter int RTW_DLY  = 1,
  parameter int DLY_W    = 4,
  parameter int PH_W     = 8,
  localparam int WL_W    = $clog2(WQ_DEPTH + 1),
  localparam int RL_W    = $clog2(RQ_DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdIssue,
  input logic             wrIssue,
  input logic             busIsWrite,
  input logic             rdForward,
  input logic             wrAccept,
  input logic             wrMerge,
  input logic [DLY_W-1:0] turnDelay,
  input logic [RL_W-1:0]  rdLevel,
  input logic [WL_W-1:0]  wrLevel,
  input logic [PH_W-1:0]  phaseCnt
);
  localparam int HI = WQ_DEPTH * HI_PCT / 100;
  localparam int LO = WQ_DEPTH * LO_PCT / 100;
  localparam int TW = (RTW_DLY < CS_DLY) ? RTW_DLY : CS_DLY;

  AST_HIGH_MARK_TURN: assert property (@(posedge clk) disable iff (!rstN)
    (!busIsWrite && int'(wrLevel) >= HI) |=> busIsWrite); // R1
  AST_IDLE_DRAIN_TURN: assert property (@(posedge clk) disable iff (!rstN)
    (!busIsWrite && rdLevel == 0 && wrLevel != 0 && int'(wrLevel) >= LO) |=> busIsWrite); // R2
  AST_MIN_WRITES_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busIsWrite && wrLevel != 0 && int'(phaseCnt) < MIN_WR) |=> busIsWrite); // R3
  AST_DELAY_TO_READS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busIsWrite) |-> int'(turnDelay) == CS_DLY); // R8
  AST_DELAY_TO_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busIsWrite) |-> int'(turnDelay) == TW); // R8
  AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (busIsWrite != $past(busIsWrite)) |-> phaseCnt == 0); // R9
  AST_FORWARD_NO_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (rdForward && !(rdIssue && !busIsWrite)) |=> rdLevel == $past(rdLevel)); // R5
  AST_MERGE_NO_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (wrMerge && !(wrIssue && busIsWrite)) |=> wrLevel == $past(wrLevel)); // R6
  AST_NO_ACCEPT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAccept && int'(wrLevel) == WQ_DEPTH)); // R7
endmodule

bind rw_turn_arbiter rwta_checker #(
  .WQ_DEPTH(WQ_DEPTH), .RQ_DEPTH(RQ_DEPTH), .HI_PCT(HI_PCT), .LO_PCT(LO_PCT),
  .MIN_WR(MIN_WR), .CS_DLY(CS_DLY), .RTW_DLY(RTW_DLY), .DLY_W(DLY_W), .PH_W(PH_W)
) i_rwta_checker (
  .clk(clk), .rstN(rstN), .rdIssue(rdIssue), .wrIssue(wrIssue), .busIsWrite(busIsWrite),
  .rdForward(rdForward), .wrAccept(wrAccept), .wrMerge(wrMerge), .turnDelay(turnDelay),
  .rdLevel(rdLevel), .wrLevel(wrLevel), .phaseCnt(phaseCnt)
);

// File: tb/test_rw_turn_arbiter.sv
module test_rw_turn_arbiter;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdReqValid = 0, wrReqValid = 0, rdIssue = 0, wrIssue = 0;
  logic [15:0] rdReqAddr = '0, wrReqAddr = '0;
  logic busIsWrite, rdAccept, rdForward, rdRetry, wrAccept, wrMerge, wrRetry;
  logic [3:0] turnDelay;
  logic [2:0] rdLevel;
  logic [3:0] wrLevel;
  logic [7:0] phaseCnt;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rw_turn_arbiter i_rw_turn_arbiter (
    .clk(clk), .rstN(rstN), .rdReqValid(rdReqValid), .rdReqAddr(rdReqAddr),
    .wrReqValid(wrReqValid), .wrReqAddr(wrReqAddr), .rdIssue(rdIssue), .wrIssue(wrIssue),
    .busIsWrite(busIsWrite), .rdAccept(rdAccept), .rdForward(rdForward), .rdRetry(rdRetry),
    .wrAccept(wrAccept), .wrMerge(wrMerge), .wrRetry(wrRetry), .turnDelay(turnDelay),
    .rdLevel(rdLevel), .wrLevel(wrLevel), .phaseCnt(phaseCnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 busIsWrite", busIsWrite, 0);
    chk("R11 wrLevel", wrLevel, 0);
    chk("R11 rdLevel", rdLevel, 0);
    chk("R11 turnDelay", turnDelay, 0);
    chk("R11 phaseCnt", phaseCnt, 0);
  endtask

  task automatic t_merge_forward;
    wrReqValid = 1; wrReqAddr = 16'h10; #1;
    chk("R6 first write accept", wrAccept, 1);
    chk("R6 first write no merge", wrMerge, 0);
    tick;
    #1;
    chk("R6 repeat write merge", wrMerge, 1);
    chk("R6 repeat write accept", wrAccept, 1);
    tick; wrReqValid = 0;
    chk("R6 level after merge", wrLevel, 1);
    rdReqValid = 1; rdReqAddr = 16'h10; #1;
    chk("R5 hit read forwarded", rdForward, 1);
    chk("R5 hit read accepted", rdAccept, 1);
    tick; rdReqAddr = 16'h55; #1;
    chk("R5 miss read not forwarded", rdForward, 0);
    tick; rdReqValid = 0;
    chk("R5 read level", rdLevel, 1);
    wrReqValid = 1; wrReqAddr = 16'h20;
    tick; wrReqValid = 0;
    chk("R6 distinct write allocates", wrLevel, 2);
    tick;
    chk("R2 queued read holds reads", busIsWrite, 0);
    rdIssue = 1; tick; rdIssue = 0;
    chk("R2 read drained", rdLevel, 0);
    chk("R9 read phase count", phaseCnt, 1);
    chk("R2 turn not yet", busIsWrite, 0);
    tick;
    chk("R2 turn to writes", busIsWrite, 1);
    chk("R8 delay to writes", turnDelay, 1);
    chk("R9 cleared on turn", phaseCnt, 0);
  endtask

  task automatic t_min_writes;
    wrIssue = 1; tick; wrIssue = 0;
    chk("R3 level after issue", wrLevel, 1);
    chk("R8 delay cleared", turnDelay, 0);
    chk("R9 write phase count", phaseCnt, 1);
    tick;
    chk("R3 held below minimum", busIsWrite, 1);
    tick;
    chk("R3 still held", busIsWrite, 1);
    wrIssue = 1; tick; wrIssue = 0;
    chk("R3 write level zero", wrLevel, 0);
    tick;
    chk("R4 back to reads", busIsWrite, 0);
    chk("R8 delay to reads", turnDelay, 2);
    chk("R9 cleared on return", phaseCnt, 0);
  endtask

  task automatic t_high_mark;
    rdReqValid = 1; rdReqAddr = 16'h60; tick; rdReqValid = 0;
    for (int i = 0; i < 6; i++) begin
      wrReqValid = 1; wrReqAddr = 16'h30 + 16'(i); tick;
      if (i == 4) chk("R1 below high mark", busIsWrite, 0);
    end
    wrReqValid = 0;
    chk("R1 level at high mark", wrLevel, 6);
    chk("R1 not yet turned", busIsWrite, 0);
    tick;
    chk("R1 turn at high mark", busIsWrite, 1);
  endtask

  task automatic t_wrong_dir;
    rdIssue = 1; tick; rdIssue = 0;
    chk("R10 read level kept", rdLevel, 1);
    chk("R10 phase kept", phaseCnt, 0);
  endtask

  task automatic t_write_full;
    for (int i = 6; i < 8; i++) begin
      wrReqValid = 1; wrReqAddr = 16'h30 + 16'(i); tick;
    end
    wrReqAddr = 16'h38; #1;
    chk("R7 write refused", wrAccept, 0);
    tick; wrReqValid = 0;
    chk("R7 level full", wrLevel, 8);
    chk("R7 no retry while full", wrRetry, 0);
    wrIssue = 1; tick; wrIssue = 0;
    chk("R7 retry pulse", wrRetry, 1);
    tick;
    chk("R7 retry single", wrRetry, 0);
    for (int i = 0; i < 6; i++) begin
      wrIssue = 1; tick;
    end
    wrIssue = 0;
    chk("R4 level below low", wrLevel, 1);
    chk("R4 still writes", busIsWrite, 1);
    tick;
    chk("R4 return below low mark", busIsWrite, 0);
  endtask

  task automatic t_read_full;
    for (int i = 1; i < 4; i++) begin
      rdReqValid = 1; rdReqAddr = 16'h100 + 16'(i); tick;
    end
    rdReqAddr = 16'h104; #1;
    chk("R7 read refused", rdAccept, 0);
    tick; rdReqValid = 0;
    chk("R7 read level full", rdLevel, 4);
    rdIssue = 1; tick; rdIssue = 0;
    chk("R7 read retry pulse", rdRetry, 1);
    chk("R9 read phase issue", phaseCnt, 1);
    chk("R10 read level after issue", rdLevel, 3);
    tick;
    chk("R7 read retry single", rdRetry, 0);
  endtask

  initial begin
    fork
      begin
        tick; tick;
        rstN = 1;
        tick;
        t_reset;
        t_merge_forward;
        t_min_writes;
        t_high_mark;
        t_wrong_dir;
        t_write_full;
        t_read_full;
        done = 1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          nChecks++; nFails++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule